// File: doc/BRIEF.md
# Guarded Control Register with Two-Stage Write Unlock

This block keeps the configuration byte of a serial memory device: a volatile write-enable flag, a second-stage register-unlock flag, a three-bit array protection code and a two-bit watchdog period select. A bus engine in front of it has already framed the serial traffic. It hands the block decoded single-byte write requests and read requests, each with a 16-bit word address. The all-ones address selects the control register. Any other address is an array location, and the block only judges whether it may be written.

Changing the stored fields takes three steps. First set the write-enable flag, then set the unlock flag, then write the new field values. That last write starts a nonvolatile programming cycle through a one-cycle strobe and clears the unlock flag. Writes that only touch the enable flags never start a programming cycle. A write attempt into a protected array region cancels a pending unlock. While the external write-protect pin is high, the stored fields cannot be changed. The protection code protects pages counted from the top of the array downward. The two watchdog bits go straight out to a watchdog timer.

Top module: `ctl_guard_reg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the write-enable and unlock flags are 0, the stored fields equal parameter NV_INIT (default 0), and nv_start_o and rd_valid_o are 0.
- R2: The control register sits at address FFFFh. Its byte layout is: bits 7:6 watchdog select, bits 5:3 protection code, bit 2 unlock flag, bit 1 write-enable flag, bit 0 always 0. ctl_o shows this byte at all times.
- R3: A register write decodes its data bits 2:1 as follows. 00 clears both flags. 01 sets the write-enable flag when the unlock flag is 0. 11 sets the unlock flag only when write-enable is already 1. 10, and 11 with write-enable 0, are ignored. None of these pulses nv_start_o or alters the stored fields.
- R4: A register write with data bits 2:1 = 01 while the unlock flag is 1 and wp_i is 0 loads data bits 7:3 into the stored fields at that edge. It pulses nv_start_o high for exactly the following cycle, clears the unlock flag and keeps write-enable at 1.
- R5: While wp_i is 1, a write that would otherwise store fields changes nothing: the fields, both flags and nv_start_o stay as they were.
- R6: The array holds 2048 bytes in 64-byte pages, addressed by addr_i bits 10:0. Protection codes 0..4 protect 0, 1, 2, 4 or 8 pages taken from the highest page downward. Codes 5..7 protect the whole array.
- R7: arr_wr_ok_o is combinational and equals the write-enable flag AND (the address in addr_i is not protected).
- R8: An array write request (address not FFFFh) to a protected location clears the unlock flag at that edge. A request to an unprotected location leaves the unlock flag as it was.
- R9: A read request at FFFFh raises rd_valid_o for exactly the next cycle, with rd_data_o equal to the register byte as it was at the request edge. A read request at any other address leaves rd_valid_o at 0.
- R10: wd_sel_o always equals register bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (models power-up) |
| wr_req_i | input | 1 | One-cycle decoded byte write request |
| rd_req_i | input | 1 | One-cycle decoded byte read request |
| addr_i | input | 16 | Word address of the request |
| wdata_i | input | 8 | Write data byte |
| wp_i | input | 1 | Write-protect pin, active high |
| ctl_o | output | 8 | Current register byte |
| wd_sel_o | output | 2 | Watchdog period select |
| arr_wr_ok_o | output | 1 | Array write allowed at addr_i |
| nv_start_o | output | 1 | One-cycle nonvolatile write start strobe |
| rd_valid_o | output | 1 | Register read data valid |
| rd_data_o | output | 8 | Register read data |

## Verification
Register state, nv_start_o and the read response all come from single flops. Their effect is due in the cycle right after the request edge. The bench drives a request on a falling edge, drops it on the next falling edge and samples all registered outputs at that same falling edge, one rising edge later. arr_wr_ok_o has no register on its path, so the bench checks it with no request pending, shortly after placing an address. The stimulus table walks the unlock ladder, wp-pin rejection, protected-write cancellation and reads. Directed steps then probe the page boundaries of each protection code.

// File: rtl/ctl_guard_pkg.sv
// Package: shared field positions and the enable-bit write codes for the
// guarded control register. Assumes an 8-bit register byte.
package ctl_guard_pkg;

    // Stored (nonvolatile) field group: watchdog select over protection code.
    typedef struct packed {
        logic [1:0] wd;
        logic [2:0] bp;
    } nv_fields_t;

    localparam int NV_W = $bits(nv_fields_t);

    // Meaning of data bits 2:1 in a register write.
    typedef enum logic [1:0] {
        EN_CLEAR  = 2'b00,
        EN_SET    = 2'b01,
        EN_BAD    = 2'b10,
        EN_UNLOCK = 2'b11
    } en_code_t;

    // Assemble the visible register byte.
    function automatic logic [7:0] pack_ctl(nv_fields_t nv, logic rwel, logic wel);
        return {nv.wd, nv.bp, rwel, wel, 1'b0};
    endfunction

endpackage

// File: rtl/ctl_guard_bpcmp.sv
// Module: decides whether an array byte address lies in the protected region.
// Pages are counted from the top of the array. Assumes at least 8 pages.
module ctl_guard_bpcmp #(
    parameter int ARR_AW = 11,
    parameter int PAGE_W = 6
) (
    input  logic [2:0]        bp_i,
    input  logic [ARR_AW-1:0] addr_i,
    output logic              prot_o
);
    localparam int PG_W   = ARR_AW - PAGE_W;
    localparam int NPG    = 1 << PG_W;
    localparam int SPAN_W = PG_W + 1;
    localparam logic [SPAN_W-1:0] NPG_V = SPAN_W'(NPG);

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] page;

    // Translate the protection code into a page count.
    always_comb begin
        unique case (bp_i)
            3'd0:    span = '0;
            3'd1:    span = SPAN_W'(1);
            3'd2:    span = SPAN_W'(2);
            3'd3:    span = SPAN_W'(4);
            3'd4:    span = SPAN_W'(8);
            default: span = NPG_V;
        endcase
        if (span > NPG_V) span = NPG_V;
    end

    // Compare the page number against the lowest protected page.
    always_comb begin
        page   = {1'b0, addr_i[ARR_AW-1:PAGE_W]};
        prot_o = (span != '0) && (page >= (NPG_V - span));
    end

endmodule

// File: rtl/ctl_guard_latch.sv
// Module: holds the write-enable flag, the unlock flag and the stored
// fields, and issues the programming strobe. Assumes requests last one cycle
// and that the register/array decode arrives already made.
module ctl_guard_latch
    import ctl_guard_pkg::*;
#(
    parameter logic [NV_W-1:0] NV_INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req_i,
    input  logic       is_reg_i,
    input  logic [7:1] wdata_i,
    input  logic       wp_i,
    input  logic       prot_i,
    output logic       wel_o,
    output logic       rwel_o,
    output nv_fields_t nv_o,
    output logic       nv_start_o
);
    logic       wel_q, wel_d;
    logic       rwel_q, rwel_d;
    nv_fields_t nv_q, nv_d;
    logic       go_d, go_q;
    en_code_t   code;

    // Next-state decode of a register or array write request.
    always_comb begin
        wel_d  = wel_q;
        rwel_d = rwel_q;
        nv_d   = nv_q;
        go_d   = 1'b0;
        code   = en_code_t'(wdata_i[2:1]);
        if (wr_req_i && is_reg_i) begin
            unique case (code)
                EN_CLEAR: begin
                    wel_d  = 1'b0;
                    rwel_d = 1'b0;
                end
                EN_SET: begin
                    if (rwel_q) begin
                        if (!wp_i) begin
                            nv_d   = nv_fields_t'(wdata_i[7:3]);
                            go_d   = 1'b1;
                            rwel_d = 1'b0;
                        end
                    end else begin
                        wel_d = 1'b1;
                    end
                end
                EN_UNLOCK: begin
                    if (wel_q) rwel_d = 1'b1;
                end
                default: ;
            endcase
        end else if (wr_req_i && prot_i) begin
            rwel_d = 1'b0;
        end
    end

    // State registers with synchronous reset to the power-up values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
            nv_q   <= nv_fields_t'(NV_INIT);
            go_q   <= 1'b0;
        end else begin
            wel_q  <= wel_d;
            rwel_q <= rwel_d;
            nv_q   <= nv_d;
            go_q   <= go_d;
        end
    end

    assign wel_o      = wel_q;
    assign rwel_o     = rwel_q;
    assign nv_o       = nv_q;
    assign nv_start_o = go_q;

    // R4: a programming strobe needs an unlock that was pending one edge back.
    a_r4_strobe_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> $past(rwel_q));
    // R4: the unlock flag is gone in the strobe cycle.
    a_r4_strobe_clears_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> !rwel_q);
    // R3: stored fields only move together with a strobe.
    a_r3_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !go_q |-> $stable(nv_q));
    // R5: no strobe follows a request made with the pin high.
    a_r5_pin_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> !$past(wp_i));
    // R3: the unlock flag never stands without write-enable.
    a_r3_unlock_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_q |-> wel_q);

endmodule

// File: rtl/ctl_guard_rdport.sv
// Module: answers a register read with one byte in the following cycle.
// Assumes read requests last one cycle; each returns a single byte.
module ctl_guard_rdport (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req_i,
    input  logic       is_reg_i,
    input  logic [7:0] ctl_i,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o
);
    logic       vld_q;
    logic [7:0] dat_q;

    // Capture the register byte on a register read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= rd_req_i && is_reg_i;
            if (rd_req_i && is_reg_i) dat_q <= ctl_i;
        end
    end

    assign rd_valid_o = vld_q;
    assign rd_data_o  = dat_q;

    // R9: valid only follows a register read request.
    a_r9_valid_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(rd_req_i && is_reg_i));
    // R9: valid data equals the byte seen at the request edge.
    a_r9_data_matches: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> (dat_q == $past(ctl_i)));

endmodule

// File: rtl/ctl_guard_reg.sv
// Module: top of the guarded control register. Decodes the reserved address,
// wires the flag/field latch, the protection compare and the read port.
// Assumes the bus engine issues at most one one-cycle request per cycle.
module ctl_guard_reg
    import ctl_guard_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ARR_AW = 11,
    parameter int PAGE_W = 6,
    parameter logic [NV_W-1:0] NV_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wp_i,
    output logic [7:0]        ctl_o,
    output logic [1:0]        wd_sel_o,
    output logic              arr_wr_ok_o,
    output logic              nv_start_o,
    output logic              rd_valid_o,
    output logic [7:0]        rd_data_o
);
    localparam logic [ADDR_W-1:0] REG_ADDR = {ADDR_W{1'b1}};

    logic       is_reg;
    logic       prot;
    logic       wel, rwel;
    nv_fields_t nv;
    logic       unused_bits;

    assign is_reg      = (addr_i == REG_ADDR);
    assign unused_bits = wdata_i[0];

    ctl_guard_bpcmp #(.ARR_AW(ARR_AW), .PAGE_W(PAGE_W)) u_bpcmp (
        .bp_i   (nv.bp),
        .addr_i (addr_i[ARR_AW-1:0]),
        .prot_o (prot)
    );

    ctl_guard_latch #(.NV_INIT(NV_INIT)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req_i   (wr_req_i),
        .is_reg_i   (is_reg),
        .wdata_i    (wdata_i[7:1]),
        .wp_i       (wp_i),
        .prot_i     (prot),
        .wel_o      (wel),
        .rwel_o     (rwel),
        .nv_o       (nv),
        .nv_start_o (nv_start_o)
    );

    ctl_guard_rdport u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req_i   (rd_req_i),
        .is_reg_i   (is_reg),
        .ctl_i      (ctl_o),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign ctl_o       = pack_ctl(nv, rwel, wel);
    assign wd_sel_o    = nv.wd;
    assign arr_wr_ok_o = wel && !prot;

    // R8: a protected array write request cancels any pending unlock.
    a_r8_prot_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !is_reg && prot) |=> !rwel);
    // R7: array writes are never allowed without write-enable.
    a_r7_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |-> !arr_wr_ok_o);
    // R3: enable-only writes never start programming.
    a_r3_no_strobe_on_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && is_reg && !rwel) |=> !nv_start_o);

endmodule

// File: tb/ctl_guard_reg_tb.sv
module ctl_guard_reg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wp = 1'b0;
    logic [7:0]  ctl;
    logic [1:0]  wd_sel;
    logic        wr_ok;
    logic        nv_start;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl_guard_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req), .rd_req_i(rd_req),
        .addr_i(addr), .wdata_i(wdata), .wp_i(wp), .ctl_o(ctl),
        .wd_sel_o(wd_sel), .arr_wr_ok_o(wr_ok), .nv_start_o(nv_start),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Drive one request on a falling edge; return at the next falling edge.
    task automatic op(input bit rd, input logic [15:0] a, input logic [7:0] d, input bit p);
        addr = a; wdata = d; wp = p;
        wr_req = !rd; rd_req = rd;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; wp = 1'b0;
    endtask

    task automatic okat(input string tag, input logic [15:0] a, input bit exp);
        addr = a;
        #1;
        chk(tag, int'(wr_ok), int'(exp));
    endtask

    // Fields: [43:40] req id, [39] read, [38:23] addr, [22:15] data,
    // [14] wp, [13:6] expected ctl, [5] expected strobe, [4] expected valid.
    localparam int NV = 15;
    localparam logic [43:0] VEC [NV] = '{
        {4'd3, 1'b0, 16'hFFFF, 8'h06, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0}, // R3 unlock with wel 0 ignored
        {4'd3, 1'b0, 16'hFFFF, 8'h02, 1'b0, 8'h02, 1'b0, 1'b0, 4'h0}, // R3 set wel
        {4'd3, 1'b0, 16'hFFFF, 8'h04, 1'b0, 8'h02, 1'b0, 1'b0, 4'h0}, // R3 code 10 ignored
        {4'd3, 1'b0, 16'hFFFF, 8'h06, 1'b0, 8'h06, 1'b0, 1'b0, 4'h0}, // R3 set unlock
        {4'd4, 1'b0, 16'hFFFF, 8'h1A, 1'b0, 8'h1A, 1'b1, 1'b0, 4'h0}, // R4 store code 3
        {4'd3, 1'b0, 16'hFFFF, 8'h06, 1'b0, 8'h1E, 1'b0, 1'b0, 4'h0}, // R3 unlock again
        {4'd5, 1'b0, 16'hFFFF, 8'hC2, 1'b1, 8'h1E, 1'b0, 1'b0, 4'h0}, // R5 pin rejects
        {4'd8, 1'b0, 16'h07FF, 8'h55, 1'b0, 8'h1A, 1'b0, 1'b0, 4'h0}, // R8 protected cancels
        {4'd3, 1'b0, 16'hFFFF, 8'h06, 1'b0, 8'h1E, 1'b0, 1'b0, 4'h0}, // R3 unlock again
        {4'd8, 1'b0, 16'h06FF, 8'h55, 1'b0, 8'h1E, 1'b0, 1'b0, 4'h0}, // R8 unprotected keeps
        {4'd4, 1'b0, 16'hFFFF, 8'hC2, 1'b0, 8'hC2, 1'b1, 1'b0, 4'h0}, // R4 store wd 3
        {4'd3, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'hC0, 1'b0, 1'b0, 4'h0}, // R3 clear flags
        {4'd9, 1'b1, 16'hFFFF, 8'h00, 1'b0, 8'hC0, 1'b0, 1'b1, 4'h0}, // R9 register read
        {4'd9, 1'b1, 16'h0010, 8'h00, 1'b0, 8'hC0, 1'b0, 1'b0, 4'h0}, // R9 array read no valid
        {4'd2, 1'b1, 16'hFFFF, 8'h00, 1'b1, 8'hC0, 1'b0, 1'b1, 4'h0}  // R2 read with pin high
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ctl", int'(ctl), 8'h00);
        chk("R1 strobe", int'(nv_start), 0);
        chk("R1 valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("vec%0d req%0d", i, v[43:40]);
            op(v[39], v[38:23], v[22:15], v[14]);
            chk({tag, " ctl"}, int'(ctl), int'(v[13:6]));
            chk({tag, " strobe"}, int'(nv_start), int'(v[5]));
            chk({tag, " valid"}, int'(rd_valid), int'(v[4]));
            if (v[4]) chk({tag, " rdata"}, int'(rd_data), int'(v[13:6]));
        end
        // R10: watchdog select follows stored bits
        chk("R10 wd_sel", int'(wd_sel), 3);
        // R4: strobe lasts one cycle only
        op(1'b1, 16'h0000, 8'h00, 1'b0);
        chk("R4 strobe single", int'(nv_start), 0);

        // R7: no write-enable, no array write
        okat("R7 wel0", 16'h0000, 1'b0);
        op(1'b0, 16'hFFFF, 8'h02, 1'b0);
        okat("R6 code0 top", 16'h07FF, 1'b1);
        // R6: code 1 protects top page only
        op(1'b0, 16'hFFFF, 8'h06, 1'b0);
        op(1'b0, 16'hFFFF, 8'h0A, 1'b0);
        chk("R4 code1 stored", int'(ctl), 8'h0A);
        chk("R10 wd cleared", int'(wd_sel), 0);
        okat("R6 code1 0x7C0", 16'h07C0, 1'b0);
        okat("R6 code1 0x7BF", 16'h07BF, 1'b1);
        // R6: code 4 protects 8 pages
        op(1'b0, 16'hFFFF, 8'h06, 1'b0);
        op(1'b0, 16'hFFFF, 8'h22, 1'b0);
        okat("R6 code4 0x600", 16'h0600, 1'b0);
        okat("R6 code4 0x5FF", 16'h05FF, 1'b1);
        // R6: code 5 protects everything, high address bits ignored
        op(1'b0, 16'hFFFF, 8'h06, 1'b0);
        op(1'b0, 16'hFFFF, 8'h2A, 1'b0);
        okat("R6 code5 0x000", 16'h0000, 1'b0);
        okat("R6 code5 0x800", 16'h0800, 1'b0);
        chk("R2 ctl layout", int'(ctl), 8'h2A);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re-reset ctl", int'(ctl), 8'h00);
        okat("R1 R7 after reset", 16'h0000, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule